// File: doc/BRIEF.md
# Dual-Channel Serial Register Front End

This block is the register-side face of a two-channel serial communications controller. A host reaches it over a plain byte-wide read/write bus. Each channel has a command port and a data port. The command port gives indirect access to sixteen write registers and sixteen read registers through a pointer. The block keeps one receive queue per channel and derives the receive-available and transmit-empty status from it. It collects interrupt causes for both channels in one pending register and drives a single interrupt request line.

A data-port write puts the byte on the transmit output for the line logic that follows. When local loopback is enabled, the same byte also goes into that channel's own receive queue. Incoming bytes arrive from the line side on a one-cycle receive strobe. Baud generation, serialization and DMA belong to other blocks.

Top module: `dual_serial_regif`

## Requirements
- R1: Address bit 3 selects the channel (1 = channel A, 0 = channel B). Offset 1 (address bits 2:0) is the command port and offset 5 is the data port. Writes to any other offset are ignored, and reads of any other offset return 0x00.
- R2: The first command-port write after an idle pointer latches bits 3:0 of the byte as the register pointer; bits 7:4 are dropped. The second command-port write stores the byte into the selected write register. The pointer then returns to 0 and the next command write is again a select.
- R3: A command-port read returns the read register named by the pointer, then returns the pointer to 0. A read with no select before it therefore returns read register 0.
- R4: Write registers 12 and 13 of a channel read back unchanged through read registers 12 and 13 of the same channel. Read registers other than 0, 3, 12 and 13 read 0x00.
- R5: Read register 0 has bit 2 (transmit empty) always set and bit 0 set while the channel's receive queue holds data; its other bits are zero. Read register 1 always reads 0x00.
- R6: A data-port write raises txValid for exactly one cycle, in the cycle after the write, with txData equal to the byte and txChan equal to the channel bit.
- R7: When bit 4 of a channel's write register 14 is set, a data-port write also pushes the byte into that channel's receive queue. If an external receive strobe hits the same channel in the same cycle, only the looped-back byte is queued.
- R8: A receive strobe pushes rxData into the queue of channel rxChan. Data-port reads pop bytes in arrival order and return 0x00 when the queue is empty.
- R9: Pending register (read register 3) layout: bit 5 = receive A, bit 4 = transmit A, bit 2 = receive B, bit 1 = transmit B; bits 3, 0, 7 and 6 read zero. A data-port write sets its channel's transmit bit only if channel A's write register 9 bit 3 (master enable) and channel A's write register 1 bit 1 (transmit enable) are both set.
- R10: While channel A's write register 1 bits 4:3 are non-zero, a channel's receive pending bit is set in the cycle after its queue is seen non-empty.
- R11: irq is high exactly when the master enable is set and either the transmit enable is set with a transmit bit pending, or the receive mode is non-zero with a receive bit pending.
- R12: A command-port read of register 3 on channel A, or any data-port read, clears the whole pending register. A command-port read of register 3 on channel B returns 0x00 and clears nothing.
- R13: Each receive queue is a 1024-entry circular buffer. When a push makes the write position equal the read position, the channel's sticky overrun bit is set (bit 1 = channel A, bit 0 = channel B), and the queue then reads as empty.
- R14: A synchronous active-high reset clears all registers, pointers, queues, pending bits, overrun flags, txValid and irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 4 | Byte address: bit 3 channel, bits 2:0 offset |
| busWr | input | 1 | Write strobe (takes priority over busRd) |
| busRd | input | 1 | Read strobe; side effects at the clock edge |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the cycle busRd is high |
| rxStrobe | input | 1 | Receive byte strobe from the line side |
| rxChan | input | 1 | Channel of the received byte (1 = A) |
| rxData | input | 8 | Received byte |
| txValid | output | 1 | One-cycle pulse for a byte to send |
| txData | output | 8 | Byte to send |
| txChan | output | 1 | Channel of the byte to send (1 = A) |
| irq | output | 1 | Interrupt request |
| overrun | output | 2 | Sticky receive overrun per channel |

## Verification
Some properties are checked on every cycle. Reads of unused offsets return zero. Reading an empty queue returns zero. Every data write is echoed on the transmit output one cycle later. Reading register 3 on channel A leaves the pending register clear. irq is never high without the master enable. Other behaviour only the bench's scenarios can show. That covers the two-write pointer protocol with its low-nibble masking and the reset of the pointer after each access. It also covers FIFO ordering, loopback winning over a colliding strobe, the pending bit layout, a channel B register 3 read leaving the pending register untouched, and the overrun after exactly 1024 pushes.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int ADDR_W = 4;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 4;
  localparam int NCHAN  = 2;

  localparam logic        CH_A     = 1'b1;
  localparam logic [2:0]  OFF_CMD  = 3'd1;
  localparam logic [2:0]  OFF_DATA = 3'd5;

  localparam logic [IDX_W-1:0] REG_STAT  = 4'd0;
  localparam logic [IDX_W-1:0] REG_IRQEN = 4'd1;
  localparam logic [IDX_W-1:0] REG_PEND  = 4'd3;
  localparam logic [IDX_W-1:0] REG_MASTR = 4'd9;
  localparam logic [IDX_W-1:0] REG_MIRLO = 4'd12;
  localparam logic [IDX_W-1:0] REG_MIRHI = 4'd13;
  localparam logic [IDX_W-1:0] REG_MISC  = 4'd14;

  localparam int BIT_TXIE  = 1;
  localparam int BIT_RXMLO = 3;
  localparam int BIT_MIE   = 3;
  localparam int BIT_LOOP  = 4;

  typedef struct packed {
    logic              chan;
    logic              cmdWrReg;
    logic              cmdRead;
    logic [IDX_W-1:0]  regIdx;
    logic              dataRead;
    logic              dataWrite;
    logic [BYTE_W-1:0] wdata;
  } dsr_strobe_t;
endpackage

// File: rtl/dsr_ctrl.sv
module dsr_ctrl
  import dsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BYTE_W-1:0] busWdata,
  output dsr_strobe_t       stb
);
  logic [NCHAN-1:0][IDX_W-1:0] ptrQ;
  logic [NCHAN-1:0]            selQ;
  logic wrEn, rdEn, isCmd, isData, chan, selectNow;

  always_comb begin
    wrEn      = busWr;
    rdEn      = busRd & ~busWr;
    chan      = busAddr[3];
    isCmd     = (busAddr[2:0] == OFF_CMD);
    isData    = (busAddr[2:0] == OFF_DATA);
    selectNow = wrEn & isCmd & ~selQ[chan];
    stb.chan      = chan;
    stb.cmdWrReg  = wrEn & isCmd & selQ[chan];
    stb.cmdRead   = rdEn & isCmd;
    stb.regIdx    = ptrQ[chan];
    stb.dataRead  = rdEn & isData;
    stb.dataWrite = wrEn & isData;
    stb.wdata     = busWdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptrQ <= '0;
      selQ <= '0;
    end else if (selectNow) begin
      ptrQ[chan] <= busWdata[IDX_W-1:0];
      selQ[chan] <= 1'b1;
    end else if (stb.cmdWrReg || stb.cmdRead) begin
      ptrQ[chan] <= '0;
      selQ[chan] <= 1'b0;
    end
  end
endmodule

// File: rtl/dsr_rxq.sv
module dsr_rxq #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic             avail,
  output logic             overrun
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wPos, rPos, wNext, rNext, rAfter;
  logic doPop;

  always_comb begin
    avail   = (wPos != rPos);
    doPop   = pop & avail;
    wNext   = (wPos == LAST) ? '0 : wPos + 1'b1;
    rNext   = (rPos == LAST) ? '0 : rPos + 1'b1;
    rAfter  = doPop ? rNext : rPos;
    popData = mem[rPos];
  end

  always_ff @(posedge clk) begin
    if (push) mem[wPos] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wPos    <= '0;
      rPos    <= '0;
      overrun <= 1'b0;
    end else begin
      if (push) begin
        wPos <= wNext;
        if (wNext == rAfter) overrun <= 1'b1;
      end
      if (doPop) rPos <= rNext;
    end
  end
endmodule

// File: rtl/dsr_datapath.sv
module dsr_datapath
  import dsr_pkg::*;
#(
  parameter int QDEPTH = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  dsr_strobe_t       stb,
  input  logic              rxStrobe,
  input  logic              rxChan,
  input  logic [BYTE_W-1:0] rxData,
  output logic [BYTE_W-1:0] busRdata,
  output logic              txValid,
  output logic [BYTE_W-1:0] txData,
  output logic              txChan,
  output logic              irq,
  output logic [NCHAN-1:0]  overrun,
  output logic              masterEn,
  output logic [5:0]        pendBits,
  output logic [NCHAN-1:0]  availBits
);
  logic [NCHAN-1:0][BYTE_W-1:0] mirLoQ, mirHiQ, popDataV;
  logic [NCHAN-1:0] loopQ, txPendQ, rxPendQ, txSet, rxSet;
  logic txIeQ;
  logic [1:0] rxModeQ;
  logic rxIe, clrPend;

  // write-register fields; only fields with a consumer are stored
  always_ff @(posedge clk) begin
    if (rst) begin
      mirLoQ <= '0; mirHiQ <= '0; loopQ <= '0;
      masterEn <= 1'b0; txIeQ <= 1'b0; rxModeQ <= '0;
    end else if (stb.cmdWrReg) begin
      for (int c = 0; c < NCHAN; c++) begin
        if (stb.chan == c[0]) begin
          if (stb.regIdx == REG_MIRLO) mirLoQ[c] <= stb.wdata;
          if (stb.regIdx == REG_MIRHI) mirHiQ[c] <= stb.wdata;
          if (stb.regIdx == REG_MISC)  loopQ[c]  <= stb.wdata[BIT_LOOP];
        end
      end
      if (stb.chan == CH_A) begin
        if (stb.regIdx == REG_MASTR) masterEn <= stb.wdata[BIT_MIE];
        if (stb.regIdx == REG_IRQEN) begin
          txIeQ   <= stb.wdata[BIT_TXIE];
          rxModeQ <= stb.wdata[BIT_RXMLO+1:BIT_RXMLO];
        end
      end
    end
  end

  genvar ch;
  generate
    for (ch = 0; ch < NCHAN; ch++) begin : g_chan
      logic loopHit, extHit;
      assign loopHit = stb.dataWrite & (stb.chan == ch[0]) & loopQ[ch];
      assign extHit  = rxStrobe & (rxChan == ch[0]);
      dsr_rxq #(.DEPTH(QDEPTH), .WIDTH(BYTE_W)) i_rxq (
        .clk(clk), .rst(rst),
        .push(loopHit | extHit),
        .pushData(loopHit ? stb.wdata : rxData),
        .pop(stb.dataRead & (stb.chan == ch[0])),
        .popData(popDataV[ch]),
        .avail(availBits[ch]),
        .overrun(overrun[ch])
      );
      assign txSet[ch] = stb.dataWrite & (stb.chan == ch[0]) & masterEn & txIeQ;
      assign rxSet[ch] = rxIe & availBits[ch];
    end
  endgenerate

  assign rxIe    = |rxModeQ;
  assign clrPend = (stb.cmdRead & (stb.chan == CH_A) & (stb.regIdx == REG_PEND))
                 | stb.dataRead;

  always_ff @(posedge clk) begin
    if (rst) begin
      txPendQ <= '0;
      rxPendQ <= '0;
    end else if (clrPend) begin
      txPendQ <= '0;
      rxPendQ <= '0;
    end else begin
      txPendQ <= txPendQ | txSet;
      rxPendQ <= rxPendQ | rxSet;
    end
  end

  assign pendBits = {rxPendQ[1], txPendQ[1], 1'b0, rxPendQ[0], txPendQ[0], 1'b0};
  assign irq = masterEn & ((txIeQ & |txPendQ) | (rxIe & |rxPendQ));

  always_comb begin
    busRdata = '0;
    if (stb.cmdRead) begin
      unique case (stb.regIdx)
        REG_STAT:  busRdata = {5'b0, 1'b1, 1'b0, availBits[stb.chan]};
        REG_PEND:  busRdata = (stb.chan == CH_A) ? {2'b0, pendBits} : '0;
        REG_MIRLO: busRdata = mirLoQ[stb.chan];
        REG_MIRHI: busRdata = mirHiQ[stb.chan];
        default:   busRdata = '0;
      endcase
    end else if (stb.dataRead) begin
      busRdata = availBits[stb.chan] ? popDataV[stb.chan] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txValid <= 1'b0; txData <= '0; txChan <= 1'b0;
    end else begin
      txValid <= stb.dataWrite;
      if (stb.dataWrite) begin
        txData <= stb.wdata;
        txChan <= stb.chan;
      end
    end
  end
endmodule

// File: rtl/dual_serial_regif.sv
module dual_serial_regif
  import dsr_pkg::*;
#(
  parameter int QDEPTH = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  logic              rxStrobe,
  input  logic              rxChan,
  input  logic [BYTE_W-1:0] rxData,
  output logic              txValid,
  output logic [BYTE_W-1:0] txData,
  output logic              txChan,
  output logic              irq,
  output logic [NCHAN-1:0]  overrun
);
  dsr_strobe_t stb;
  logic masterEn;
  logic [5:0] pendBits;
  logic [NCHAN-1:0] availBits;

  dsr_ctrl i_ctrl (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .busWdata(busWdata), .stb(stb)
  );

  dsr_datapath #(.QDEPTH(QDEPTH)) i_dp (
    .clk(clk), .rst(rst), .stb(stb),
    .rxStrobe(rxStrobe), .rxChan(rxChan), .rxData(rxData),
    .busRdata(busRdata), .txValid(txValid), .txData(txData), .txChan(txChan),
    .irq(irq), .overrun(overrun), .masterEn(masterEn),
    .pendBits(pendBits), .availBits(availBits)
  );
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker
  import dsr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [BYTE_W-1:0] busWdata,
  input logic [BYTE_W-1:0] busRdata,
  input logic              txValid,
  input logic [BYTE_W-1:0] txData,
  input logic              irq,
  input logic              masterEn,
  input logic [5:0]        pendBits,
  input logic [NCHAN-1:0]  availBits,
  input dsr_strobe_t       stb
);
  // R1: unused offsets read as zero
  p_unused_offset_r1: assert property (@(posedge clk) disable iff (rst)
    (busRd && !busWr && busAddr[2:0] != OFF_CMD && busAddr[2:0] != OFF_DATA)
      |-> busRdata == '0);

  // R6: each data write appears on the transmit output next cycle
  p_tx_echo_r6: assert property (@(posedge clk) disable iff (rst)
    (busWr && busAddr[2:0] == OFF_DATA) |=> (txValid && txData == $past(busWdata)));

  // R8: empty queue reads zero
  p_empty_read_r8: assert property (@(posedge clk) disable iff (rst)
    (stb.dataRead && !availBits[stb.chan]) |-> busRdata == '0);

  // R11: no request without master enable
  p_irq_master_r11: assert property (@(posedge clk) disable iff (rst)
    irq |-> masterEn);

  // R12: reading the pending register on channel A leaves it clear
  p_pend_clear_r12: assert property (@(posedge clk) disable iff (rst)
    (stb.cmdRead && stb.chan == CH_A && stb.regIdx == REG_PEND) |=> pendBits == '0);
endmodule

bind dual_serial_regif dsr_checker i_dsr_checker (
  .clk(clk), .rst(rst), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
  .busWdata(busWdata), .busRdata(busRdata), .txValid(txValid), .txData(txData),
  .irq(irq), .masterEn(masterEn), .pendBits(pendBits), .availBits(availBits),
  .stb(stb)
);

// File: tb/test_dual_serial_regif.sv
`timescale 1ns/1ps
module test_dual_serial_regif;
  localparam logic [3:0] A_CMD = 4'h9, A_DAT = 4'hD, B_CMD = 4'h1, B_DAT = 4'h5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] busAddr = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic rxStrobe = 1'b0, rxChan = 1'b0;
  logic [7:0] rxData = '0;
  logic txValid, txChan, irq;
  logic [7:0] txData;
  logic [1:0] overrun;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;
  logic [7:0] expRd[$];
  string      tagRd[$];
  logic [8:0] expTx[$];

  always #4 clk = ~clk;

  dual_serial_regif i_dual_serial_regif (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .rxStrobe(rxStrobe),
    .rxChan(rxChan), .rxData(rxData), .txValid(txValid), .txData(txData),
    .txChan(txChan), .irq(irq), .overrun(overrun)
  );

  task automatic tally(input bit ok, input string tag, input int got, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    tally(got == exp, tag, got, exp);
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic regWrite(input logic [3:0] cmd, input logic [7:0] idx, input logic [7:0] d);
    busWrite(cmd, idx);
    busWrite(cmd, d);
  endtask

  task automatic sendByte(input logic [3:0] a, input logic [7:0] d);
    expTx.push_back({a[3], d});
    busWrite(a, d);
  endtask

  task automatic readExp(input logic [3:0] a, input logic [7:0] exp, input string tag);
    expRd.push_back(exp);
    tagRd.push_back(tag);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic rxPush(input logic c, input logic [7:0] d);
    @(negedge clk);
    rxStrobe = 1'b1; rxChan = c; rxData = d;
    @(negedge clk);
    rxStrobe = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    #2;
  endtask

  // monitor: compares read data and transmit output against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (busRd) begin
        if (expRd.size() == 0) tally(1'b0, "R3 unexpected read", busRdata, 0);
        else begin
          logic [7:0] e;
          string t;
          e = expRd.pop_front();
          t = tagRd.pop_front();
          tally(busRdata == e, t, busRdata, e);
        end
      end
      if (txValid) begin
        if (expTx.size() == 0) tally(1'b0, "R6 unexpected tx", {txChan, txData}, 0);
        else begin
          logic [8:0] e;
          e = expTx.pop_front();
          tally({txChan, txData} == e, "R6 tx byte", {txChan, txData}, e);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    // R14 reset state
    chk("R14 irq after reset", irq, 0);
    chk("R14 overrun after reset", overrun, 0);
    chk("R14 txValid after reset", txValid, 0);
    readExp(A_CMD, 8'h04, "R14 R5 status after reset");

    // R4 mirror registers, R2 two-write protocol
    regWrite(B_CMD, 8'd12, 8'h5A);
    busWrite(B_CMD, 8'd12);
    readExp(B_CMD, 8'h5A, "R4 mirror 12 B");
    regWrite(B_CMD, 8'd13, 8'hC3);
    busWrite(B_CMD, 8'd13);
    readExp(B_CMD, 8'hC3, "R4 mirror 13 B");
    readExp(B_CMD, 8'h04, "R3 read without select");
    busWrite(B_CMD, 8'hFC);
    readExp(B_CMD, 8'h5A, "R2 upper nibble dropped");
    busWrite(B_CMD, 8'hF2);
    readExp(B_CMD, 8'h00, "R4 unused read reg");
    readExp(B_CMD, 8'h04, "R3 pointer back to 0");

    // R1 decode and channel separation
    regWrite(A_CMD, 8'd12, 8'h99);
    busWrite(4'h8, 8'h0C);
    readExp(A_CMD, 8'h04, "R1 offset 0 write ignored");
    readExp(4'hA, 8'h00, "R1 offset 2 reads zero");
    readExp(4'h2, 8'h00, "R1 offset 2 B reads zero");
    busWrite(A_CMD, 8'd12);
    readExp(A_CMD, 8'h99, "R1 channel A mirror");
    busWrite(A_CMD, 8'd1);
    readExp(A_CMD, 8'h00, "R5 error register zero");

    // R6 transmit without loopback
    sendByte(B_DAT, 8'h41);
    readExp(B_CMD, 8'h04, "R7 no loopback when disabled");

    // R7 loopback, R8 ordering
    regWrite(B_CMD, 8'd14, 8'h10);
    sendByte(B_DAT, 8'h77);
    sendByte(B_DAT, 8'h78);
    readExp(B_CMD, 8'h05, "R5 receive available");
    readExp(B_DAT, 8'h77, "R8 first byte");
    readExp(B_DAT, 8'h78, "R8 second byte");
    readExp(B_DAT, 8'h00, "R8 empty read");
    readExp(B_CMD, 8'h04, "R5 drained");

    // R7 loopback beats a colliding external strobe
    expTx.push_back({1'b0, 8'h55});
    @(negedge clk);
    busAddr = B_DAT; busWdata = 8'h55; busWr = 1'b1;
    rxStrobe = 1'b1; rxChan = 1'b0; rxData = 8'h66;
    @(negedge clk);
    busWr = 1'b0; rxStrobe = 1'b0;
    readExp(B_DAT, 8'h55, "R7 loopback wins");
    readExp(B_DAT, 8'h00, "R7 strobe dropped");

    // R8 external receive on A
    rxPush(1'b1, 8'h33);
    rxPush(1'b1, 8'h34);
    readExp(A_CMD, 8'h05, "R8 A available");
    readExp(A_DAT, 8'h33, "R8 A first");
    readExp(A_DAT, 8'h34, "R8 A second");

    // R10 R11 receive interrupts
    rxPush(1'b0, 8'h99);
    repeat (3) @(negedge clk);
    settle();
    chk("R11 no enables", irq, 0);
    busWrite(A_CMD, 8'd3);
    readExp(A_CMD, 8'h00, "R10 receive mode off");
    regWrite(A_CMD, 8'd1, 8'h08);
    repeat (2) @(negedge clk);
    settle();
    chk("R11 master off", irq, 0);
    regWrite(A_CMD, 8'd9, 8'h08);
    settle();
    chk("R11 receive irq", irq, 1);
    busWrite(A_CMD, 8'd3);
    readExp(A_CMD, 8'h04, "R9 R10 receive B bit");
    readExp(B_DAT, 8'h99, "R8 pop under irq");
    settle();
    chk("R12 data read clears", irq, 0);

    // R9 R12 transmit interrupts
    regWrite(B_CMD, 8'd14, 8'h00);
    regWrite(A_CMD, 8'd1, 8'h02);
    sendByte(B_DAT, 8'h21);
    settle();
    chk("R11 transmit irq", irq, 1);
    busWrite(B_CMD, 8'd3);
    readExp(B_CMD, 8'h00, "R12 channel B reg 3");
    settle();
    chk("R12 B read keeps irq", irq, 1);
    busWrite(A_CMD, 8'd3);
    readExp(A_CMD, 8'h02, "R9 transmit B bit");
    settle();
    chk("R12 pending read clears", irq, 0);
    sendByte(A_DAT, 8'h22);
    busWrite(A_CMD, 8'd3);
    readExp(A_CMD, 8'h10, "R9 transmit A bit");
    sendByte(A_DAT, 8'h23);
    settle();
    chk("R11 transmit A irq", irq, 1);
    readExp(A_DAT, 8'h00, "R12 data read on empty");
    settle();
    chk("R12 data read clears tx", irq, 0);
    regWrite(A_CMD, 8'd9, 8'h00);
    sendByte(B_DAT, 8'h24);
    busWrite(A_CMD, 8'd3);
    readExp(A_CMD, 8'h00, "R9 master gate");
    settle();
    chk("R11 irq with master off", irq, 0);

    // R13 overrun on channel A
    for (int i = 0; i < 1023; i++) rxPush(1'b1, 8'(i));
    settle();
    chk("R13 no overrun at 1023", overrun, 0);
    readExp(A_CMD, 8'h05, "R13 nearly full");
    rxPush(1'b1, 8'hEE);
    settle();
    chk("R13 overrun flag", overrun, 2);
    readExp(A_CMD, 8'h04, "R13 wrapped reads empty");

    repeat (4) @(negedge clk);
    #3;
    chk("R6 pending tx drained", expTx.size(), 0);
    chk("R3 pending reads drained", expRd.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule